// File: doc/BRIEF.md
# Banked Filter Coefficient Loader

This block holds three independent banks of 64 filter coefficients, each 24 bits wide, and lets a host fill or inspect them through a small window of byte-wide registers. The host picks a target bank and a 6-bit coefficient index. It then fills up to five 24-bit staging slots, most significant byte first, and sets a trigger bit in a control register. The block then commits one slot, or all five slots to consecutive indices (one biquad's worth), into the target bank. A third trigger copies a stored coefficient back into staging slot 0 so that the host can read it through the same byte registers.

On the processing side, a signal-path engine reads any bank at any index with a fixed one-cycle latency. The engine switches presets by changing the bank code it reads, and it never has to wait. A commit that would land on the location the engine is reading in that same cycle is held back until the engine moves away. Each trigger bit stays set while its operation is pending and clears by itself when the operation completes.

Neither side has back-pressure. Host register writes are accepted or ignored in the cycle they are presented, and engine reads always return data one cycle later. Instead of a ready signal, the host polls the control register until it reads zero before it issues new writes.

Top module: `coef_bank_loader`

## Requirements
- R1: After reset every coefficient in every bank reads zero, and the bank, index, staging and control registers all read zero.
- R2: The register window is laid out as follows. Address 0 holds the target bank in bits 1:0. Address 1 holds the index in bits 5:0. Staging slot s (0..4) uses addresses 2+3s, 3+3s and 4+3s for its top, middle and bottom bytes. Address 17 is the control register. Reads return the stored values, unused bits read 0, and addresses above 17 read 0 and ignore writes.
- R3: Writing control bit 0 starts a single commit. On the next clock edge, unless that edge is deferred by R7, slot 0 is written to the target bank at the index, and bit 0 reads 0 after that edge.
- R4: Writing control bit 1 starts a burst commit. Slot k is written to index (index+k) mod 64, one slot per clock edge in slot order. Bit 1 clears on the edge that writes slot 4.
- R5: Writing control bit 2 starts a readback. On the next edge the target-bank entry at the index is copied into staging slot 0, and bit 2 clears on that edge.
- R6: When a control write sets more than one trigger bit, only the operation of the lowest-numbered set bit runs. The control register then shows only that bit.
- R7: A commit that targets the same bank and index the engine reads in that cycle is deferred by one cycle at a time. Its trigger bit stays set until the commit completes.
- R8: When dsp_rd_en is high at a clock edge, dsp_rd_data after that edge equals the coefficient stored at dsp_bank/dsp_idx before the edge. Bank code 3 returns 0. The output holds its value while dsp_rd_en is low.
- R9: With target bank code 3, a commit completes and clears its bit but leaves every bank unchanged. A readback from bank code 3 loads zero.
- R10: While any trigger bit is set, host writes to every register, including the control register, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 5 | Host register address (also selects read data) |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Byte at reg_addr (combinational) |
| dsp_rd_en | input | 1 | Engine read request |
| dsp_bank | input | 2 | Bank code read by the engine |
| dsp_idx | input | 6 | Coefficient index read by the engine |
| dsp_rd_data | output | 24 | Coefficient returned one cycle after the request |

## Verification
The embedded assertions check these rules on every cycle: a commit never writes the location the engine reads in the same cycle, bank code 3 is never written, the burst counter stays in range, a pending trigger freezes the bank and index registers, a single commit without a collision clears its trigger, and reads of bank code 3 return zero. Only the bench scenarios can show the rest. These are the byte ordering within a coefficient, index wrap-around during a burst, the data that readback returns, the priority among trigger bits set together, and the count of deferred cycles under a sustained collision. The bench checks these against its behavioural model on every cycle.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_SINGLE = 2'd1,
    OP_BURST  = 2'd2,
    OP_READ   = 2'd3
  } cbl_op_e;
endpackage

// File: rtl/cbl_regs.sv
module cbl_regs
  import cbl_pkg::*;
#(
  parameter int CW = 24,
  parameter int IW = 6,
  parameter int NS = 5,
  parameter int BW = 2,
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic             op_done,
  input  logic             load_en,
  input  logic [CW-1:0]    load_data,
  output logic [BW-1:0]    bank,
  output logic [IW-1:0]    idx,
  output logic [NS*CW-1:0] slots,
  output cbl_op_e          op,
  output logic [7:0]       reg_rdata
);
  localparam int NB    = CW / 8;
  localparam int SLOT0 = 2;
  localparam int CTRL  = SLOT0 + NB * NS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank  <= '0;
      idx   <= '0;
      slots <= '0;
      op    <= OP_NONE;
    end else begin
      if (op == OP_NONE && reg_wr) begin
        if (reg_addr == AW'(0)) bank <= reg_wdata[BW-1:0];
        if (reg_addr == AW'(1)) idx  <= reg_wdata[IW-1:0];
        for (int s = 0; s < NS; s++) begin
          for (int b = 0; b < NB; b++) begin
            if (reg_addr == AW'(SLOT0 + s * NB + b))
              slots[s*CW + (NB-1-b)*8 +: 8] <= reg_wdata;
          end
        end
        if (reg_addr == AW'(CTRL)) begin
          if (reg_wdata[0])      op <= OP_SINGLE;
          else if (reg_wdata[1]) op <= OP_BURST;
          else if (reg_wdata[2]) op <= OP_READ;
        end
      end
      if (op_done) op <= OP_NONE;
      if (load_en) slots[CW-1:0] <= load_data;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(0)) reg_rdata[BW-1:0] = bank;
    if (reg_addr == AW'(1)) reg_rdata[IW-1:0] = idx;
    for (int s = 0; s < NS; s++) begin
      for (int b = 0; b < NB; b++) begin
        if (reg_addr == AW'(SLOT0 + s * NB + b))
          reg_rdata = slots[s*CW + (NB-1-b)*8 +: 8];
      end
    end
    if (reg_addr == AW'(CTRL))
      reg_rdata = {5'b0, op == OP_READ, op == OP_BURST, op == OP_SINGLE};
  end

  // R10: a pending trigger freezes target selection
  a_r10_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_NONE && reg_wr) |=> ($stable(bank) && $stable(idx)));

  // R6: lowest set trigger bit wins
  a_r6_single_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE && reg_wr && reg_addr == AW'(CTRL) && reg_wdata[0]) |=> op == OP_SINGLE);
endmodule

// File: rtl/cbl_engine.sv
module cbl_engine
  import cbl_pkg::*;
#(
  parameter int CW    = 24,
  parameter int IW    = 6,
  parameter int NS    = 5,
  parameter int BW    = 2,
  parameter int NBANK = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cbl_op_e          op,
  input  logic [BW-1:0]    bank,
  input  logic [IW-1:0]    idx,
  input  logic [NS*CW-1:0] slots,
  input  logic             dsp_rd_en,
  input  logic [BW-1:0]    dsp_bank,
  input  logic [IW-1:0]    dsp_idx,
  input  logic [CW-1:0]    host_rdata,
  output logic             ram_we,
  output logic [BW-1:0]    ram_wbank,
  output logic [IW-1:0]    ram_widx,
  output logic [CW-1:0]    ram_wdata,
  output logic             op_done,
  output logic             load_en,
  output logic [CW-1:0]    load_data
);
  localparam int KW = (NS > 1) ? $clog2(NS) : 1;

  logic [KW-1:0] k;
  logic          conflict, commit, last;

  always_comb begin
    ram_widx  = idx + IW'(k);
    conflict  = dsp_rd_en && (dsp_bank == bank) && (dsp_idx == ram_widx);
    commit    = (op == OP_SINGLE || op == OP_BURST) && !conflict;
    last      = (op == OP_SINGLE) || (k == KW'(NS - 1));
    ram_we    = commit && (bank < BW'(NBANK));
    ram_wbank = bank;
    ram_wdata = slots[int'(k)*CW +: CW];
    load_en   = (op == OP_READ);
    load_data = host_rdata;
    op_done   = (commit && last) || load_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      k <= '0;
    else if (commit) k <= last ? '0 : k + KW'(1);
  end

  // R7: a commit never lands on the location being read
  a_r7_no_collide: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && dsp_rd_en) |-> !(ram_wbank == dsp_bank && ram_widx == dsp_idx));

  // R4: burst slot counter stays within the staged slots
  a_r4_k_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(k) < NS);

  // R3: an unobstructed single commit clears its trigger
  a_r3_single_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SINGLE && !(dsp_rd_en && dsp_bank == bank && dsp_idx == idx)) |=> op == OP_NONE);
endmodule

// File: rtl/cbl_ram.sv
module cbl_ram #(
  parameter int CW    = 24,
  parameter int IW    = 6,
  parameter int NBANK = 3,
  parameter int BW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [BW-1:0] wbank,
  input  logic [IW-1:0] widx,
  input  logic [CW-1:0] wdata,
  input  logic          dsp_rd_en,
  input  logic [BW-1:0] dsp_bank,
  input  logic [IW-1:0] dsp_idx,
  output logic [CW-1:0] dsp_rd_data,
  input  logic [BW-1:0] h_bank,
  input  logic [IW-1:0] h_idx,
  output logic [CW-1:0] h_rdata
);
  localparam int DEPTH = 1 << IW;

  logic [CW-1:0] d_word [NBANK];
  logic [CW-1:0] h_word [NBANK];
  logic [CW-1:0] d_sel;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [CW-1:0] mem [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && wbank == BW'(g)) begin
        mem[widx] <= wdata;
      end
    end
    assign d_word[g] = mem[dsp_idx];
    assign h_word[g] = mem[h_idx];
  end

  always_comb begin
    d_sel   = '0;
    h_rdata = '0;
    for (int g = 0; g < NBANK; g++) begin
      if (dsp_bank == BW'(g)) d_sel   = d_word[g];
      if (h_bank == BW'(g))   h_rdata = h_word[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dsp_rd_data <= '0;
    else if (dsp_rd_en) dsp_rd_data <= d_sel;
  end

  // R9: the unused bank code is never written
  a_r9_bank_valid: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wbank < BW'(NBANK)));

  // R8: reads of the unused bank code return zero
  a_r8_empty_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_rd_en && dsp_bank >= BW'(NBANK)) |=> dsp_rd_data == '0);
endmodule

// File: rtl/coef_bank_loader.sv
module coef_bank_loader
  import cbl_pkg::*;
#(
  parameter  int CW     = 24,
  parameter  int IW     = 6,
  parameter  int NS     = 5,
  parameter  int NBANK  = 3,
  localparam int BW     = $clog2(NBANK + 1),
  localparam int REG_AW = $clog2(2 + (CW / 8) * NS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              dsp_rd_en,
  input  logic [BW-1:0]     dsp_bank,
  input  logic [IW-1:0]     dsp_idx,
  output logic [CW-1:0]     dsp_rd_data
);
  logic [BW-1:0]    bank, ram_wbank;
  logic [IW-1:0]    idx, ram_widx;
  logic [NS*CW-1:0] slots;
  cbl_op_e          op;
  logic             op_done, load_en, ram_we;
  logic [CW-1:0]    load_data, host_rdata, ram_wdata;

  cbl_regs #(.CW(CW), .IW(IW), .NS(NS), .BW(BW), .AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .op_done(op_done), .load_en(load_en),
    .load_data(load_data), .bank(bank), .idx(idx), .slots(slots),
    .op(op), .reg_rdata(reg_rdata));

  cbl_engine #(.CW(CW), .IW(IW), .NS(NS), .BW(BW), .NBANK(NBANK)) u_engine (
    .clk(clk), .rst_n(rst_n), .op(op), .bank(bank), .idx(idx),
    .slots(slots), .dsp_rd_en(dsp_rd_en), .dsp_bank(dsp_bank),
    .dsp_idx(dsp_idx), .host_rdata(host_rdata), .ram_we(ram_we),
    .ram_wbank(ram_wbank), .ram_widx(ram_widx), .ram_wdata(ram_wdata),
    .op_done(op_done), .load_en(load_en), .load_data(load_data));

  cbl_ram #(.CW(CW), .IW(IW), .NBANK(NBANK), .BW(BW)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(ram_we), .wbank(ram_wbank),
    .widx(ram_widx), .wdata(ram_wdata), .dsp_rd_en(dsp_rd_en),
    .dsp_bank(dsp_bank), .dsp_idx(dsp_idx), .dsp_rd_data(dsp_rd_data),
    .h_bank(bank), .h_idx(idx), .h_rdata(host_rdata));
endmodule

// File: tb/coef_bank_loader_test.sv
module coef_bank_loader_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [4:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        dsp_rd_en = 0;
  logic [1:0]  dsp_bank = 0;
  logic [5:0]  dsp_idx = 0;
  logic [23:0] dsp_rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int mem [3][64];
  int slot [5];
  int m_bank, m_idx, m_op, m_k, m_dout;

  coef_bank_loader uut (.*);

  always #10 clk = ~clk;

  function automatic int mreg(int a);
    if (a == 0) return m_bank;
    if (a == 1) return m_idx;
    if (a >= 2 && a <= 16) return (slot[(a-2)/3] >> ((2 - (a-2)%3) * 8)) & 255;
    if (a == 17) return (m_op == 1) ? 1 : (m_op == 2) ? 2 : (m_op == 3) ? 4 : 0;
    return 0;
  endfunction

  always @(posedge clk) begin
    int tgt, a, sh;
    bit conf;
    if (!rst_n) begin
      foreach (mem[b, i]) mem[b][i] = 0;
      foreach (slot[s]) slot[s] = 0;
      m_bank = 0; m_idx = 0; m_op = 0; m_k = 0; m_dout = 0;
    end else begin
      if (dsp_rd_en) m_dout = (dsp_bank < 3) ? mem[dsp_bank][dsp_idx] : 0;
      if (m_op == 0) begin
        if (reg_wr) begin
          a = reg_addr;
          if (a == 0) m_bank = reg_wdata & 3;
          else if (a == 1) m_idx = reg_wdata & 63;
          else if (a >= 2 && a <= 16) begin
            sh = (2 - (a-2)%3) * 8;
            slot[(a-2)/3] = (slot[(a-2)/3] & ~(255 << sh)) | (int'(reg_wdata) << sh);
          end else if (a == 17)
            m_op = reg_wdata[0] ? 1 : reg_wdata[1] ? 2 : reg_wdata[2] ? 3 : 0;
        end
      end else begin
        tgt  = (m_idx + m_k) % 64;
        conf = dsp_rd_en && dsp_bank == m_bank && dsp_idx == tgt;
        if (m_op == 3) begin
          slot[0] = (m_bank < 3) ? mem[m_bank][m_idx] : 0;
          m_op = 0;
        end else if (!conf) begin
          if (m_bank < 3) mem[m_bank][tgt] = slot[m_k];
          if (m_op == 1 || m_k == 4) begin m_op = 0; m_k = 0; end
          else m_k++;
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock; per-cycle comparison against the model
  task automatic tick();
    @(negedge clk);
    #1;
    chk("R2 reg readback", reg_rdata, mreg(reg_addr));
    chk("R8 engine read", dsp_rd_data, m_dout);
  endtask

  task automatic wr(int a, int d);
    reg_addr = 5'(a); reg_wdata = 8'(d); reg_wr = 1;
    tick();
    reg_wr = 0;
  endtask

  task automatic peek(string tag, int a, int exp);
    reg_addr = 5'(a);
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic eread(string tag, int b, int i, int exp);
    dsp_rd_en = 1; dsp_bank = 2'(b); dsp_idx = 6'(i);
    tick();
    dsp_rd_en = 0;
    chk(tag, dsp_rd_data, exp);
  endtask

  task automatic put_slot(int s, int v);
    wr(2 + 3*s, (v >> 16) & 255);
    wr(3 + 3*s, (v >> 8) & 255);
    wr(4 + 3*s, v & 255);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1: reset state
    peek("R1 ctrl", 17, 0);
    peek("R1 bank", 0, 0);
    peek("R1 slot byte", 9, 0);
    eread("R1 ram zero", 2, 40, 0);

    // R2: register layout and readback
    wr(0, 8'hFD);
    peek("R2 bank bits", 0, 1);
    wr(1, 8'hC5);
    peek("R2 index bits", 1, 5);
    put_slot(0, 24'hA1B2C3);
    peek("R2 top byte", 2, 8'hA1);
    peek("R2 bottom byte", 4, 8'hC3);
    wr(20, 8'h55);
    peek("R2 unused addr", 20, 0);

    // R3: single commit
    wr(17, 1);
    peek("R3 bit pending", 17, 1);
    tick();
    peek("R3 bit cleared", 17, 0);
    eread("R3 stored", 1, 5, 24'hA1B2C3);
    eread("R8 other bank", 0, 5, 0);

    // R4: burst with index wrap
    wr(0, 2); wr(1, 62);
    for (int s = 0; s < 5; s++) put_slot(s, 24'h100000 + s * 24'h010101);
    wr(17, 2);
    for (int c = 0; c < 4; c++) begin
      peek("R4 bit held", 17, 2);
      tick();
    end
    tick();
    peek("R4 bit cleared", 17, 0);
    eread("R4 slot0 idx62", 2, 62, 24'h100000);
    eread("R4 slot2 wrap idx0", 2, 0, 24'h120202);
    eread("R4 slot4 idx2", 2, 2, 24'h140404);

    // R5: readback into slot 0
    wr(1, 63);
    put_slot(0, 24'hDEAD01);
    wr(17, 4);
    tick();
    peek("R5 cleared", 17, 0);
    peek("R5 top", 2, 8'h11);
    peek("R5 bottom", 4, 8'h01);

    // R6: bits 0 and 2 together -> single only
    wr(1, 10);
    put_slot(0, 24'h0F0E0D);
    wr(17, 5);
    peek("R6 only single", 17, 1);
    tick();
    peek("R6 slot kept", 2, 8'h0F);
    eread("R6 committed", 2, 10, 24'h0F0E0D);

    // R7: collision defers the commit
    wr(0, 1); wr(1, 7);
    put_slot(0, 24'h777777);
    dsp_rd_en = 1; dsp_bank = 1; dsp_idx = 7;
    wr(17, 1);
    tick(); tick();
    peek("R7 still pending", 17, 1);
    dsp_rd_en = 0;
    tick();
    peek("R7 completed", 17, 0);
    eread("R7 stored", 1, 7, 24'h777777);

    // R10: writes ignored while busy
    wr(1, 20);
    wr(17, 2);
    wr(1, 33);
    peek("R10 index kept", 1, 20);
    wr(17, 4);
    repeat (5) tick();
    peek("R10 ctrl write ignored", 17, 0);

    // R9: bank code 3 leaves banks unchanged
    wr(0, 3); wr(1, 5);
    put_slot(0, 24'h333333);
    wr(17, 1);
    tick();
    peek("R9 cleared", 17, 0);
    eread("R9 bank1 intact", 1, 5, 24'hA1B2C3);
    eread("R8 bank3 zero", 3, 5, 0);
    wr(17, 4);
    tick();
    peek("R9 readback zero", 3, 0);
    dsp_rd_en = 0;
    tick();
    chk("R8 hold", dsp_rd_data, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule